// File: doc/BRIEF.md
# E1 Receive Performance Error Counter Bank

This block accumulates line and framing error counts for a single E1 receiver. It watches the dual-rail receive inputs and finds polarity violations. It also takes per-event pulses from the framer for FAS word errors, CRC4 block errors and received E-bits. It counts all of these over an accumulation window that is measured in received frames. The host selects either a long window (8000 frames, one second) or a short window (500 frames, 62.5 ms).

At every window boundary the live totals are copied into holding registers, and a one-cycle window event is raised so the host knows fresh totals are ready. The holding registers are read through a byte-wide address/data path. The counters share byte addresses. The host has a full window to read one set of totals before the next set replaces it.

The violation counter has two modes. In the first it counts bipolar violations, and it can optionally skip the violations that belong to HDB3 substitution words. In the second it counts code violations. The violation counter saturates, and it never stops counting. The CRC4, E-bit and FAS counters pause while the relevant level of synchronisation is lost. Loss of CAS multiframe alignment is not an input, because it gates no counter. The E-bit strobe comes from upstream logic that has already picked bit 1 of frames 13 and 15 of the CRC4 multiframe.

Top module: `e1_err_bank`

## Requirements
- R1: A window closes on the frame_tick pulse that completes FRAMES_SHORT frames (short_win=1) or FRAMES_LONG frames (short_win=0) since the previous boundary. win_evt is high for exactly the one clock after that pulse.
- R2: At a boundary the holding registers take the live totals accumulated before the boundary cycle. An event that arrives in the boundary cycle itself is counted in the next window.
- R3: With cv_sel=0 and hdb3_en=0, a mark is a cycle with exactly one rail high, and its polarity is negative when rx_neg is high. A bipolar violation is a mark with the same polarity as the previous mark, and each one adds 1 to the violation count. A cycle with both rails high changes nothing.
- R4: With cv_sel=1, only code violations are counted. A code violation is a bipolar violation whose polarity equals that of the previous bipolar violation.
- R5: With cv_sel=0 and hdb3_en=1, a bipolar violation is not counted when both of the following hold: it follows exactly 2 or 3 zero bits (cycles with both rails low), and its polarity is opposite to the previous bipolar violation, or there was no previous bipolar violation.
- R6: The 16-bit violation count saturates at 65535 and does not wrap. It counts whatever the values of los_fas and los_crc.
- R7: The 10-bit CRC4 error count (crc_err pulses) and the 10-bit E-bit count do not advance while los_fas or los_crc is high.
- R8: The E-bit count advances on a cycle with ebit_stb=1 and ebit_val=0. A cycle with ebit_stb=1 and ebit_val=1 does not advance it.
- R9: The 12-bit FAS error count (fas_err pulses) pauses only while los_fas is high. los_crc has no effect on it.
- R10: rd_data is combinational from rd_addr:
  - 0 = violation[15:8]
  - 1 = violation[7:0]
  - 2 = {6'b0, crc[9:8]}
  - 3 = crc[7:0]
  - 4 = {2'b0, fas[11:6]}
  - 5 = {fas[5:0], ebit[9:8]}
  - 6 = ebit[7:0]
  - 7 = 8'h00
- R11: After reset all holding registers read 0 and win_evt is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_pos | input | 1 | Positive rail receive data |
| rx_neg | input | 1 | Negative rail receive data |
| frame_tick | input | 1 | One-cycle pulse per received frame |
| short_win | input | 1 | 1 = short window, 0 = long window |
| cv_sel | input | 1 | 1 = count code violations, 0 = bipolar violations |
| hdb3_en | input | 1 | Skip HDB3 substitution violations in bipolar mode |
| fas_err | input | 1 | FAS word error pulse |
| crc_err | input | 1 | CRC4 block error pulse |
| ebit_stb | input | 1 | Received E-bit valid strobe |
| ebit_val | input | 1 | Received E-bit value |
| los_fas | input | 1 | Loss of frame alignment |
| los_crc | input | 1 | Loss of CRC4 multiframe alignment |
| rd_addr | input | 3 | Holding register byte address |
| rd_data | output | 8 | Holding register byte |
| win_evt | output | 1 | Window boundary event, one cycle |

## Verification
The window boundary and a counted event can fall in the same cycle. In that case the increment has to miss the totals being frozen and appear in the new window. The bench provokes this by placing a same-polarity mark together with FAS, CRC4 and zero E-bit pulses on the final frame pulse of a window. It then expects the closing window to report zero for all four counts and the following quiet window to report exactly one for each. A second coincidence is saturation at the boundary: the window after the saturating one must restart from zero.

// File: rtl/e1_err_pkg.sv
package e1_err_pkg;
    localparam int VIOL_W = 16;
    localparam int CRC_W  = 10;
    localparam int EBIT_W = 10;
    localparam int FAS_W  = 12;
    localparam int ZRUN_W = 3;
    localparam logic [ZRUN_W-1:0] ZRUN_MAX = ZRUN_W'(4);

    typedef struct packed {
        logic              seen;   // any mark since reset
        logic              pol;    // polarity of last mark, 1 = negative
        logic              vseen;  // any bipolar violation since reset
        logic              vpol;   // polarity of last bipolar violation
        logic [ZRUN_W-1:0] zrun;   // zero bits since last mark, saturating
    } vdet_st_t;
endpackage

// File: rtl/e1_viol_det.sv
module e1_viol_det
    import e1_err_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pos,
    input  logic neg,
    input  logic cv_sel,
    input  logic hdb3_en,
    output logic viol_inc
);
    vdet_st_t s_q, s_d;
    logic mark, pol, bpv, same_v, hdb3_word;

    always_comb begin
        s_d       = s_q;
        mark      = pos ^ neg;
        pol       = neg;
        bpv       = mark && s_q.seen && (pol == s_q.pol);
        same_v    = s_q.vseen && (pol == s_q.vpol);
        hdb3_word = ((s_q.zrun == ZRUN_W'(2)) || (s_q.zrun == ZRUN_W'(3))) && !same_v;
        if (cv_sel) begin
            viol_inc = bpv && same_v;
        end else begin
            viol_inc = bpv && !(hdb3_en && hdb3_word);
        end
        if (mark) begin
            s_d.seen = 1'b1;
            s_d.pol  = pol;
            s_d.zrun = '0;
            if (bpv) begin
                s_d.vseen = 1'b1;
                s_d.vpol  = pol;
            end
        end else if (!pos && !neg) begin
            s_d.zrun = (s_q.zrun == ZRUN_MAX) ? ZRUN_MAX : s_q.zrun + ZRUN_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R3: a cycle with both rails high leaves the polarity history untouched
    a_r3_both_rails_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (pos && neg) |=> $stable(s_q));

    // R4: a code violation needs an earlier bipolar violation on record
    a_r4_cv_needs_history: assert property (@(posedge clk) disable iff (!rst_n)
        (cv_sel && viol_inc) |-> s_q.vseen);

    // R3: no violation can be reported without a single-rail mark
    a_r3_viol_on_mark: assert property (@(posedge clk) disable iff (!rst_n)
        viol_inc |-> (pos != neg));
endmodule

// File: rtl/e1_win_timer.sv
module e1_win_timer #(
    parameter int FRAMES_LONG  = 8000,
    parameter int FRAMES_SHORT = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_tick,
    input  logic short_win,
    output logic boundary,
    output logic win_evt
);
    localparam int CW = $clog2(FRAMES_LONG + 1);
    localparam logic [CW-1:0] LIM_L = CW'(FRAMES_LONG - 1);
    localparam logic [CW-1:0] LIM_S = CW'(FRAMES_SHORT - 1);

    logic [CW-1:0] cnt_q, cnt_d, lim;
    logic          evt_q, evt_d;

    always_comb begin
        lim      = short_win ? LIM_S : LIM_L;
        boundary = frame_tick && (cnt_q >= lim);
        cnt_d    = cnt_q;
        if (frame_tick) cnt_d = boundary ? '0 : cnt_q + CW'(1);
        evt_d    = boundary;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            evt_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            evt_q <= evt_d;
        end
    end

    assign win_evt = evt_q;

    // R1: the window event always follows a frame pulse
    a_r1_evt_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        win_evt |-> $past(frame_tick));

    // R1: the frame count never passes the long limit
    a_r1_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIM_L);
endmodule

// File: rtl/e1_err_ctr.sv
module e1_err_ctr #(
    parameter int W   = 10,
    parameter bit SAT = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         en,
    input  logic         boundary,
    output logic [W-1:0] hold
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    logic [W-1:0] live_q, live_d, hold_q, hold_d, bumped;
    logic         inc_eff;

    generate
        if (SAT) begin : g_sat
            assign bumped = (live_q == MAXV) ? MAXV : live_q + W'(1);
        end else begin : g_wrap
            assign bumped = live_q + W'(1);
        end
    endgenerate

    always_comb begin
        inc_eff = inc && en;
        hold_d  = hold_q;
        live_d  = live_q;
        if (boundary) begin
            hold_d = live_q;
            live_d = W'(inc_eff);
        end else if (inc_eff) begin
            live_d = bumped;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live_q <= '0;
            hold_q <= '0;
        end else begin
            live_q <= live_d;
            hold_q <= hold_d;
        end
    end

    assign hold = hold_q;

    // R6: a saturating counter stays at its ceiling inside a window
    a_r6_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (SAT && (live_q == MAXV) && !boundary) |=> (live_q == MAXV));

    // R7 / R9: a paused counter does not move inside a window
    a_r7_paused_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !boundary) |=> $stable(live_q));

    // R2: holding value changes only at a boundary
    a_r2_hold_only_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> $stable(hold_q));
endmodule

// File: rtl/e1_err_bank.sv
module e1_err_bank
    import e1_err_pkg::*;
#(
    parameter int FRAMES_LONG  = 8000,
    parameter int FRAMES_SHORT = 500
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_pos,
    input  logic       rx_neg,
    input  logic       frame_tick,
    input  logic       short_win,
    input  logic       cv_sel,
    input  logic       hdb3_en,
    input  logic       fas_err,
    input  logic       crc_err,
    input  logic       ebit_stb,
    input  logic       ebit_val,
    input  logic       los_fas,
    input  logic       los_crc,
    input  logic [2:0] rd_addr,
    output logic [7:0] rd_data,
    output logic       win_evt
);
    logic              boundary, viol_inc, ebit_zero, deep_ok, frame_ok;
    logic [VIOL_W-1:0] viol_h;
    logic [CRC_W-1:0]  crc_h;
    logic [EBIT_W-1:0] ebit_h;
    logic [FAS_W-1:0]  fas_h;

    assign ebit_zero = ebit_stb && !ebit_val;
    assign deep_ok   = !los_fas && !los_crc;
    assign frame_ok  = !los_fas;

    e1_win_timer #(.FRAMES_LONG(FRAMES_LONG), .FRAMES_SHORT(FRAMES_SHORT)) u_timer (
        .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .short_win(short_win),
        .boundary(boundary), .win_evt(win_evt)
    );

    e1_viol_det u_vdet (
        .clk(clk), .rst_n(rst_n), .pos(rx_pos), .neg(rx_neg),
        .cv_sel(cv_sel), .hdb3_en(hdb3_en), .viol_inc(viol_inc)
    );

    e1_err_ctr #(.W(VIOL_W), .SAT(1'b1)) u_viol (
        .clk(clk), .rst_n(rst_n), .inc(viol_inc), .en(1'b1),
        .boundary(boundary), .hold(viol_h)
    );

    e1_err_ctr #(.W(CRC_W), .SAT(1'b0)) u_crc (
        .clk(clk), .rst_n(rst_n), .inc(crc_err), .en(deep_ok),
        .boundary(boundary), .hold(crc_h)
    );

    e1_err_ctr #(.W(EBIT_W), .SAT(1'b0)) u_ebit (
        .clk(clk), .rst_n(rst_n), .inc(ebit_zero), .en(deep_ok),
        .boundary(boundary), .hold(ebit_h)
    );

    e1_err_ctr #(.W(FAS_W), .SAT(1'b0)) u_fas (
        .clk(clk), .rst_n(rst_n), .inc(fas_err), .en(frame_ok),
        .boundary(boundary), .hold(fas_h)
    );

    // R10: byte map of the holding registers
    always_comb begin
        case (rd_addr)
            3'd0:    rd_data = viol_h[15:8];
            3'd1:    rd_data = viol_h[7:0];
            3'd2:    rd_data = {6'b0, crc_h[9:8]};
            3'd3:    rd_data = crc_h[7:0];
            3'd4:    rd_data = {2'b0, fas_h[11:6]};
            3'd5:    rd_data = {fas_h[5:0], ebit_h[9:8]};
            3'd6:    rd_data = ebit_h[7:0];
            default: rd_data = 8'h00;
        endcase
    end

    // R11: the window event cannot appear without a frame pulse having been seen
    a_r11_quiet_evt: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(frame_tick)) |-> !win_evt);
endmodule

// File: tb/e1_err_bank_tb.sv
`timescale 1ns/100ps
module e1_err_bank_tb;
    localparam int NL = 8;
    localparam int NS = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_pos = 0, rx_neg = 0, frame_tick = 0, short_win = 1, cv_sel = 0, hdb3_en = 0;
    logic fas_err = 0, crc_err = 0, ebit_stb = 0, ebit_val = 0, los_fas = 0, los_crc = 0;
    logic [2:0] rd_addr = 3'd0;
    logic [7:0] rd_data;
    logic       win_evt;

    always #4 clk = ~clk;

    e1_err_bank #(.FRAMES_LONG(NL), .FRAMES_SHORT(NS)) u_dut (
        .clk(clk), .rst_n(rst_n), .rx_pos(rx_pos), .rx_neg(rx_neg), .frame_tick(frame_tick),
        .short_win(short_win), .cv_sel(cv_sel), .hdb3_en(hdb3_en), .fas_err(fas_err),
        .crc_err(crc_err), .ebit_stb(ebit_stb), .ebit_val(ebit_val), .los_fas(los_fas),
        .los_crc(los_crc), .rd_addr(rd_addr), .rd_data(rd_data), .win_evt(win_evt)
    );

    typedef struct { int v; int c; int f; int e; string tag; } exp_t;
    exp_t q[$];
    int total = 0, bad = 0, evt_cnt = 0;
    bit done = 0;

    task automatic check(input string tag, input string what, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    task automatic tick(input logic p, input logic n, input logic fe, input logic ce,
                        input logic es, input logic ev, input logic ft);
        @(negedge clk);
        rx_pos = p; rx_neg = n; fas_err = fe; crc_err = ce;
        ebit_stb = es; ebit_val = ev; frame_tick = ft;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic rails(input string s);
        for (int i = 0; i < s.len(); i++) begin
            case (s[i])
                "P": tick(1, 0, 0, 0, 0, 0, 0);
                "N": tick(0, 1, 0, 0, 0, 0, 0);
                "B": tick(1, 1, 0, 0, 0, 0, 0);
                default: tick(0, 0, 0, 0, 0, 0, 0);
            endcase
        end
    endtask

    task automatic errs(input int nf, input int nc, input int ne0, input int ne1);
        for (int i = 0; i < nf; i++)  tick(0, 0, 1, 0, 0, 0, 0);
        for (int i = 0; i < nc; i++)  tick(0, 0, 0, 1, 0, 0, 0);
        for (int i = 0; i < ne0; i++) tick(0, 0, 0, 0, 1, 0, 0);
        for (int i = 0; i < ne1; i++) tick(0, 0, 0, 0, 1, 1, 0);
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) tick(0, 0, 0, 0, 0, 0, 1);
        tick(0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic expect_win(input int v, input int c, input int f, input int e, input string tag);
        exp_t x;
        x.v = v; x.c = c; x.f = f; x.e = e; x.tag = tag;
        q.push_back(x);
    endtask

    // monitor: reset state, then one comparison set per window event
    initial begin
        logic [7:0] b[8];
        exp_t x;
        @(posedge rst_n);
        @(negedge clk);
        for (int a = 0; a < 8; a++) begin
            rd_addr = 3'(a); #1;
            check("R11", $sformatf("reset byte %0d", a), int'(rd_data), 0);
        end
        check("R11", "reset win_evt", int'(win_evt), 0);
        forever begin
            @(negedge clk);
            if (win_evt === 1'b1) begin
                evt_cnt++;
                for (int a = 0; a < 7; a++) begin
                    rd_addr = 3'(a); #1;
                    b[a] = rd_data;
                end
                rd_addr = 3'd7;
                b[7] = 8'h00;
                if (q.size() == 0) begin
                    check("R1", "unexpected window event", 1, 0);
                end else begin
                    x = q.pop_front();
                    check(x.tag, "violation", int'({b[0], b[1]}), x.v);
                    check(x.tag, "crc4", int'({b[2][1:0], b[3]}), x.c);
                    check(x.tag, "fas", int'({b[4][5:0], b[5][7:2]}), x.f);
                    check(x.tag, "ebit", int'({b[5][1:0], b[6]}), x.e);
                    check("R10", "unused bits", int'({b[2][7:2], b[4][7:6]}), 0);
                end
            end
        end
    end

    // driver
    initial begin
        int ev0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(3);

        // window 1: bipolar mode, both-rail cycle ignored, ebit value 1 ignored
        short_win = 1; cv_sel = 0; hdb3_en = 0;
        errs(3, 2, 2, 1);
        rails("NPP0NNPNBP");
        expect_win(2, 2, 3, 2, "R3 R8");
        ev0 = evt_cnt;
        pulses(NS - 1);
        idle(2);
        check("R1", "no event before short limit", evt_cnt, ev0);
        pulses(1);
        idle(2);
        check("R1", "event at short limit", evt_cnt, ev0 + 1);

        // window 2: code violation mode
        cv_sel = 1;
        errs(1, 1, 1, 0);
        rails("NNPPNPPN");
        expect_win(2, 1, 1, 1, "R4");
        pulses(NS);
        idle(3);

        // window 3: HDB3-aware bipolar mode, frame sync lost
        cv_sel = 0; hdb3_en = 1; los_fas = 1;
        errs(2, 2, 2, 0);
        rails("P000PN00NP000PP");
        expect_win(2, 0, 0, 0, "R5 R7 R9");
        pulses(NS);
        idle(3);

        // window 4: long window, CRC4 sync lost only
        hdb3_en = 0; los_fas = 0; los_crc = 1; short_win = 0;
        errs(2, 2, 2, 0);
        expect_win(0, 0, 2, 0, "R7 R9 R1");
        ev0 = evt_cnt;
        pulses(NS);
        idle(2);
        check("R1", "long window open after short count", evt_cnt, ev0);
        pulses(NL - NS);
        idle(2);
        check("R1", "event at long limit", evt_cnt, ev0 + 1);

        // window 5: saturation under loss of frame sync
        los_crc = 0; los_fas = 1; short_win = 1;
        for (int i = 0; i < 65600; i++) tick(1, 0, 0, 0, 0, 0, 0);
        idle(1);
        expect_win(65535, 0, 0, 0, "R6");
        pulses(NS);
        idle(3);

        // window 6: boundary cycle carries a violation and all error pulses
        los_fas = 0;
        expect_win(0, 0, 0, 0, "R2");
        for (int i = 0; i < NS - 1; i++) tick(0, 0, 0, 0, 0, 0, 1);
        tick(1, 0, 1, 1, 1, 0, 1);
        idle(3);
        // window 7: the boundary-cycle events land here
        expect_win(1, 1, 1, 1, "R2");
        pulses(NS);
        idle(4);

        check("R2", "all windows reported", q.size(), 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(150000 * 8);
        if (!done) begin
            check("R1", "watchdog expired", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule